// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Through Data Cache

This block is a read/write data cache that sits between a processor-side request port and a slower memory port. A byte address is divided into three fields. The top 22 bits form the tag. The next 8 bits select one of 256 sets. The lowest 2 bits pick a byte within a 32-bit word, and the cache ignores them. Each set has four ways, and each way holds a valid flag, a tag and one data word. All four ways of the addressed set are compared in parallel, and a selector returns the word from the way that hits.

A read hit completes in the cycle in which it is presented. On a read miss the processor is stalled: `cpu_ready` stays low while the word is fetched over the memory handshake. The fetched word is written into a way of the set, and the lookup is then replayed, so that it hits. Writes are write-through. A write always goes to memory. On a hit the cached word is updated as well. On a miss the cache is left alone (no allocate). Replacement is true LRU within each set, and empty ways are used before any valid way is evicted. A synchronous reset invalidates every line.

The processor holds `cpu_req` and its address and data stable until it sees `cpu_ready` high at a rising edge. The memory side holds its request until `mem_ack`, which may arrive after any number of cycles.

Top module: `assoc4_dcache`

## Requirements
- R1: The cache selects the set with address bits 9..2 and compares bits 31..10 as the tag. Bits 1..0 do not affect hit or data. Every memory address the cache issues has bits 1..0 equal to zero.
- R2: A read that hits raises `cpu_ready` in the cycle it is presented, returns the stored word on `cpu_rdata`, and issues no memory request.
- R3: On a read miss, `cpu_ready` stays low while `mem_req` is high with `mem_we` low. After the `mem_ack` cycle the replayed lookup completes one cycle later and returns the fetched word. With an acknowledge delay of L wait cycles, the read takes L+3 cycles.
- R4: On a write hit, memory is written (`mem_we` high, `mem_wdata` equal to `cpu_wdata`) and `cpu_ready` rises in the `mem_ack` cycle. A later read of that word hits and returns the new data. With an acknowledge delay of L, the write takes L+2 cycles.
- R5: On a write miss, only memory is written. A later read of that word misses and fetches it from memory.
- R6: When a set is full, a fill evicts the least recently used way. Read hits, write hits and fills all make a way most recently used. Invalid ways are filled before any valid way is evicted.
- R7: Reset clears every valid bit and drives `cpu_ready` and `mem_req` low. The first read of any address after reset misses.
- R8: `mem_req`, `mem_we` and `mem_addr` are held stable from the rise of `mem_req` until the `mem_ack` cycle. The acknowledge latency may vary from one access to the next.
- R9: Accesses to one set never change hit or miss outcomes in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | Request completes at this rising edge |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request in this cycle |

## Verification
The hardest condition to reach is an eviction whose victim depends on a mixed history of hits, fills and write hits within one full set. Hitting ways must be reordered without disturbing the others. A plain fill pattern cannot tell true LRU apart from FIFO or a pseudo-LRU scheme. The stimulus therefore first fills one set with four tags. It then touches an older tag and brings in a fifth, and follows with a long random run over six tags in two sets, with mixed reads and writes and acknowledge delays of zero to three cycles. A queue-based model in the bench predicts every hit, every miss and every cycle count.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2
   } dc_state_e;
endpackage

// File: rtl/dc_store.sv
`timescale 1ns/1ps
module dc_store #(
   parameter int SET_W  = 8,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 22,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [SET_W-1:0]         idx,
   input  logic [WAYS-1:0]          wr_en,
   input  logic [TAG_W-1:0]         wr_tag,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [WAYS-1:0]          rd_vld,
   output logic [WAYS*TAG_W-1:0]    rd_tag,
   output logic [WAYS*DATA_W-1:0]   rd_data
);
   localparam int SETS = 1 << SET_W;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]   vld_q;
      logic [TAG_W-1:0]  tag_mem [SETS];
      logic [DATA_W-1:0] dat_mem [SETS];

      always_ff @(posedge clk) begin
         if (rst)
            vld_q <= '0;
         else if (wr_en[w])
            vld_q[idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (wr_en[w]) begin
            tag_mem[idx] <= wr_tag;
            dat_mem[idx] <= wr_data;
         end
      end

      assign rd_vld[w]                     = vld_q[idx];
      assign rd_tag[w*TAG_W +: TAG_W]      = tag_mem[idx];
      assign rd_data[w*DATA_W +: DATA_W]   = dat_mem[idx];
   end
endmodule

// File: rtl/dc_lookup.sv
`timescale 1ns/1ps
module dc_lookup #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 22,
   parameter int DATA_W = 32
) (
   input  logic [WAYS-1:0]          way_vld,
   input  logic [WAYS*TAG_W-1:0]    way_tag,
   input  logic [WAYS*DATA_W-1:0]   way_data,
   input  logic [TAG_W-1:0]         req_tag,
   output logic                     hit,
   output logic [WAYS-1:0]          hit_vec,
   output logic [$clog2(WAYS)-1:0]  hit_way,
   output logic [DATA_W-1:0]        hit_data
);
   localparam int WAY_W = $clog2(WAYS);

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_vld[w] && (way_tag[w*TAG_W +: TAG_W] == req_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way  = '0;
      hit_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_way  = WAY_W'(w);
            hit_data = way_data[w*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/dc_lru.sv
`timescale 1ns/1ps
module dc_lru #(
   parameter int SET_W = 8,
   parameter int WAYS  = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [SET_W-1:0]         idx,
   input  logic [WAYS-1:0]          way_vld,
   input  logic                     touch_en,
   input  logic [$clog2(WAYS)-1:0]  touch_way,
   output logic [$clog2(WAYS)-1:0]  victim
);
   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = $clog2(WAYS);

   // age 0 = most recent, WAYS-1 = oldest; each set holds a permutation
   logic [WAY_W-1:0] age_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[idx][w] <= '0;
            else if (age_q[idx][w] < age_q[idx][touch_way])
               age_q[idx][w] <= age_q[idx][w] + 1'b1;
         end
      end
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !way_vld[w]) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++)
            if (age_q[idx][w] == WAY_W'(WAYS-1))
               victim = WAY_W'(w);
      end
   end
endmodule

// File: rtl/assoc4_dcache.sv
`timescale 1ns/1ps
module assoc4_dcache
   import dc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SET_W  = 8,
   parameter int WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int TAG_W = ADDR_W - SET_W - OFF_W;
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if ((8 << OFF_W) != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for SET_W and DATA_W");
   end

   logic [SET_W-1:0]        req_idx;
   logic [TAG_W-1:0]        req_tag;
   logic                    dbg_unused_off;
   logic [WAYS-1:0]         st_vld;
   logic [WAYS*TAG_W-1:0]   st_tag;
   logic [WAYS*DATA_W-1:0]  st_data;
   logic [WAYS-1:0]         st_wr_en;
   logic [DATA_W-1:0]       st_wr_data;
   logic                    hit;
   logic [WAYS-1:0]         hit_vec;
   logic [WAY_W-1:0]        hit_way;
   logic [DATA_W-1:0]       hit_data;
   logic [WAY_W-1:0]        victim;
   logic                    touch_en;
   logic [WAY_W-1:0]        touch_way;
   logic                    fill_now;
   logic                    wr_hit_now;
   logic                    rd_hit_now;
   dc_state_e               state_q, state_d;

   assign req_idx        = cpu_addr[OFF_W +: SET_W];
   assign req_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
   assign dbg_unused_off = ^cpu_addr[OFF_W-1:0];

   dc_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .idx     (req_idx),
      .wr_en   (st_wr_en),
      .wr_tag  (req_tag),
      .wr_data (st_wr_data),
      .rd_vld  (st_vld),
      .rd_tag  (st_tag),
      .rd_data (st_data)
   );

   dc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
      .way_vld  (st_vld),
      .way_tag  (st_tag),
      .way_data (st_data),
      .req_tag  (req_tag),
      .hit      (hit),
      .hit_vec  (hit_vec),
      .hit_way  (hit_way),
      .hit_data (hit_data)
   );

   dc_lru #(.SET_W(SET_W), .WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst       (rst),
      .idx       (req_idx),
      .way_vld   (st_vld),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .victim    (victim)
   );

   // control
   assign rd_hit_now = (state_q == ST_IDLE) && cpu_req && !cpu_we && hit;
   assign fill_now   = (state_q == ST_FILL) && mem_ack;
   assign wr_hit_now = (state_q == ST_WRITE) && mem_ack && hit;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (cpu_req && cpu_we)
               state_d = ST_WRITE;
            else if (cpu_req && !hit)
               state_d = ST_FILL;
         end
         ST_FILL:  if (mem_ack) state_d = ST_IDLE;
         ST_WRITE: if (mem_ack) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   always_comb begin
      st_wr_en   = '0;
      st_wr_data = cpu_wdata;
      if (fill_now) begin
         st_wr_en   = WAYS'(1) << victim;
         st_wr_data = mem_rdata;
      end else if (wr_hit_now) begin
         st_wr_en   = hit_vec;
      end
   end

   assign touch_en  = rd_hit_now || fill_now || wr_hit_now;
   assign touch_way = fill_now ? victim : hit_way;

   assign cpu_ready = rd_hit_now || ((state_q == ST_WRITE) && mem_ack);
   assign cpu_rdata = hit_data;
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/dc_checker.sv
`timescale 1ns/1ps
module dc_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WAYS   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic [WAYS-1:0]   wr_en
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R1

   AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we) |-> !cpu_ready); // R3

   AST_REPLAY_HIT: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we && mem_ack && cpu_req) |=> cpu_ready); // R3

   AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we && cpu_ready) |-> (mem_req && mem_we && mem_ack && mem_wdata == cpu_wdata)); // R4

   AST_UPDATE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
      (wr_en != '0) |-> (mem_req && mem_ack)); // R5

   AST_ONE_WAY_WRITTEN: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_en)); // R6

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!mem_req && !cpu_ready)); // R7

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
endmodule

bind assoc4_dcache dc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_wdata (cpu_wdata),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .wr_en     (st_wr_en)
);

// File: tb/sim_assoc4_dcache.sv
`timescale 1ns/1ps
module sim_assoc4_dcache;
   logic        clk = 1'b0;
   logic        rst;
   logic        cpu_req, cpu_we;
   logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
   logic        cpu_ready;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ack;

   int errs   = 0;
   int checks = 0;
   bit ended  = 0;

   // reference model: per-set recency queue of tags (front = newest)
   logic [21:0] rq [256][$];
   logic [31:0] cval [logic [29:0]];
   logic [31:0] mval [logic [29:0]];

   always #5 clk = ~clk;

   assoc4_dcache u0 (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic logic [31:0] mem_get(logic [29:0] wa);
      if (mval.exists(wa)) return mval[wa];
      return {wa, 2'b00} ^ 32'h5A5A_C3C3;
   endfunction

   function automatic logic [31:0] mk(logic [21:0] tag, logic [7:0] idx, logic [1:0] off);
      return {tag, idx, off};
   endfunction

   task automatic chk(bit ok, string tg, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", tg, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      mem_ack = 1'b0; mem_rdata = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      chk(cpu_ready == 1'b0, "R7", "cpu_ready in reset", 32'(cpu_ready), 0);
      chk(mem_req == 1'b0, "R7", "mem_req in reset", 32'(mem_req), 0);
      @(negedge clk);
      rst = 1'b0;
      foreach (rq[i]) rq[i].delete();
      cval.delete();
   endtask

   task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, int lat, string tg);
      logic [29:0] wa  = addr[31:2];
      logic [7:0]  idx = addr[9:2];
      logic [21:0] tag = addr[31:10];
      int pos = -1;
      int cycles = 0, memtx = 0, waitc = 0, expc;
      bit done = 0;
      logic [31:0] got = '0, expd;
      for (int i = 0; i < rq[idx].size(); i++)
         if (rq[idx][i] == tag) pos = i;
      expd = (pos >= 0) ? cval[wa] : mem_get(wa);
      expc = we ? lat + 2 : ((pos >= 0) ? 1 : lat + 3);

      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      while (!done && cycles < 64) begin
         #1;
         cycles++;
         if (mem_req && !mem_ack) begin
            if (waitc == 0) begin
               memtx++;
               chk(mem_we == we, tg, "mem_we", 32'(mem_we), 32'(we));
               if (we) chk(mem_wdata == wd, tg, "mem_wdata", mem_wdata, wd);
            end
            chk(mem_addr == {wa, 2'b00}, "R8", "mem_addr held", mem_addr, {wa, 2'b00});
            if (waitc == lat) begin
               mem_ack = 1'b1;
               mem_rdata = we ? 32'hDEAD_BEEF : mem_get(wa);
            end else begin
               waitc++;
            end
         end
         #1;
         if (cpu_ready) begin
            done = 1;
            got  = cpu_rdata;
         end
         @(negedge clk);
         mem_ack = 1'b0;
      end
      cpu_req = 1'b0;

      chk(cycles == expc, tg, "cycle count", cycles, expc);
      chk(memtx == ((we || pos < 0) ? 1 : 0), tg, "memory transactions", memtx, (we || pos < 0) ? 1 : 0);
      if (!we) chk(got == expd, tg, "read data", got, expd);

      // update model
      if (we) mval[wa] = wd;
      if (pos >= 0) begin
         rq[idx].delete(pos);
         rq[idx].push_front(tag);
         if (we) cval[wa] = wd;
      end else if (!we) begin
         if (rq[idx].size() == 4) begin
            logic [21:0] ev = rq[idx].pop_back();
            cval.delete({ev, idx});
         end
         rq[idx].push_front(tag);
         cval[wa] = mem_get(wa);
      end
   endtask

   initial begin
      #1_000_000;
      if (!ended) begin
         ended = 1;
         checks++; errs++;
         $display("FAIL R8 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R7: first access after reset misses; R3 miss timing; R2 hit
      access(0, mk(22'h00A, 8'h10, 2'b00), 0, 2, "R7");
      access(0, mk(22'h00A, 8'h10, 2'b00), 0, 0, "R2");
      // R1: byte offset ignored, different tag same set misses
      access(0, mk(22'h00A, 8'h10, 2'b11), 0, 0, "R1");
      access(0, mk(22'h00B, 8'h10, 2'b01), 0, 1, "R1");
      access(0, mk(22'h00C, 8'h11, 2'b00), 0, 0, "R3");

      // R4: write hit, then read hit with new data
      access(1, mk(22'h00A, 8'h10, 2'b00), 32'h1234_5678, 1, "R4");
      access(0, mk(22'h00A, 8'h10, 2'b10), 0, 0, "R4");

      // R5: write miss, read misses and fetches written word
      access(1, mk(22'h0F0, 8'h20, 2'b00), 32'hCAFE_0001, 0, "R5");
      access(0, mk(22'h0F0, 8'h20, 2'b00), 0, 3, "R5");

      // R6: fill 4, touch oldest, fifth evicts the least recent
      for (int t = 0; t < 4; t++) access(0, mk(22'(t + 32), 8'h05, 2'b00), 0, 0, "R6");
      access(0, mk(22'd32, 8'h05, 2'b00), 0, 0, "R6");
      access(1, mk(22'd34, 8'h05, 2'b00), 32'hABCD_0002, 0, "R6");
      access(0, mk(22'd36, 8'h05, 2'b00), 0, 1, "R6");
      access(0, mk(22'd33, 8'h05, 2'b00), 0, 0, "R6");
      access(0, mk(22'd32, 8'h05, 2'b00), 0, 0, "R6");
      access(0, mk(22'd34, 8'h05, 2'b00), 0, 0, "R6");
      access(0, mk(22'd35, 8'h05, 2'b00), 0, 2, "R6");

      // R9: neighbour sets do not interfere
      for (int t = 0; t < 5; t++) access(0, mk(22'(t + 64), 8'h06, 2'b00), 0, 0, "R9");
      access(0, mk(22'd64, 8'h07, 2'b00), 0, 0, "R9");
      access(0, mk(22'd34, 8'h05, 2'b00), 0, 0, "R9");
      access(0, mk(22'd68, 8'h06, 2'b00), 0, 0, "R9");

      // R8: random mix with variable latency
      for (int n = 0; n < 400; n++) begin
         logic [21:0] tg  = 22'($urandom_range(0, 5) + 100);
         logic [7:0]  ix  = ($urandom_range(0, 1) == 0) ? 8'h03 : 8'hC8;
         logic [1:0]  off = 2'($urandom_range(0, 3));
         bit          w   = ($urandom_range(0, 2) == 0);
         access(w, mk(tg, ix, off), $urandom, $urandom_range(0, 3), "R8");
      end

      // R7: reset invalidates previously cached lines
      do_reset();
      access(0, mk(22'd34, 8'h05, 2'b00), 0, 0, "R7");
      access(0, mk(22'h00A, 8'h10, 2'b00), 0, 1, "R7");

      if (!ended) begin
         ended = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule